// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a simple request/ready client and one SDRAM device with four internal banks. It turns each single-word read or write request into the right command sequence on the device pins. The command lines are chip select, row strobe, column strobe and write enable, and they are driven together with a multiplexed row/column address, a bank select and the clock enable. Every output is registered on the rising clock edge. Each bank keeps its row open until that row has to change. A row hit goes straight to the column command, and a row miss first closes the bank and then opens the new row. The client can also ask for the row to be closed automatically as part of the column command.

After reset, the sequencer holds the clock enable low for a parameterised settling time. It then closes all banks, issues two refreshes and loads the mode word (single-beat bursts, sequential order, CAS latency 3). Only after that does it accept requests. From then on, an internal timer raises a refresh demand at a fixed interval. The default interval meets 4096 refreshes in 64 ms at a 7.5 ns clock. A pending refresh is served before any further client request. Any open banks are closed first.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted, the clock enable is low, the command is NOP, req_ready is low and rd_valid is low.
- R2: After reset, the clock enable stays low for at least INIT_WAIT cycles and then rises. The first four commands are: PRECHARGE with address bit 10 set, AUTO REFRESH, AUTO REFRESH, and MODE SET with address 12'h030. No request is accepted before the mode set.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} use only these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE SET 0000. The clock enable is never low outside power-up.
- R4: After each non-NOP command, NOP cycles hold the next command off by the minimum spacing for the command just issued. The spacing is at least T_RCD cycles after ACTIVE, at least T_RP after PRECHARGE, at least T_RFC after AUTO REFRESH and at least T_MRD after MODE SET.
- R5: The flat request address is {row[22:11], bank[10:9], column[8:0]}. ACTIVE drives the row on the address pins and the bank on the bank pins. A column command drives the column on address bits 8:0 and is only issued to a bank whose row is open.
- R6: req_ready is high only in the cycle in which the request's column command is decided. That READ or WRITE appears on the pins at the next clock edge.
- R7: rd_valid pulses for one cycle exactly three cycles after a READ is driven. rd_data then holds the device data sampled at that edge.
- R8: A WRITE drives req_wdata with the data output enable high. It drives one mask bit per byte, set where req_be is 0, so masked bytes are left unchanged. The output enable is low for every other command.
- R9: A request to an open bank with the same row issues no ACTIVE or PRECHARGE. A request to an open bank with a different row issues PRECHARGE for that bank only (bit 10 low), and then ACTIVE.
- R10: With req_close set, the column command carries address bit 10 high and the bank is left closed. The next access to that bank issues ACTIVE without a PRECHARGE.
- R11: A refresh falls due every REF_INTERVAL cycles. It is issued only when all banks are closed. A PRECHARGE with bit 10 set is issued first if any bank is open. Consecutive refreshes are at most REF_INTERVAL + T_RCD + 2*T_RP + 2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_close | input | 1 | Close the row with the column command |
| req_addr | input | 23 | Flat word address {row, bank, column} |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables for a write |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Returned read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Command chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dq_out | output | DW | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | DW/8 | Byte mask, 1 = masked |
| sd_dq_in | input | DW | Data returned by the device |

## Verification
The two functions that collide are a refresh falling due and a client request waiting in the idle state. In the same decision cycle both want the command bus. The bench provokes this by streaming back-to-back requests across many short refresh intervals, so that the demand lands at every phase of an access: during an ACTIVE wait, after an auto-close, and on an idle cycle with a request present. The outcome is judged at the pins by a bank model in the bench. Every AUTO REFRESH must find all banks closed, and the refresh spacing must stay inside its bound. Every read must still return the data that the bench's own byte-merged memory predicts.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int AP_BIT = 10;
    localparam int CAS_LAT = 3;

    // single-beat bursts, sequential order, latency 3, burst writes
    localparam logic [ROW_W-1:0] MODE_WORD = 12'h030;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_INIT_PRE,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MRS,
        ST_IDLE
    } seq_state_e;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split
    import sdram_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);
    assign col  = addr[COL_W-1:0];
    assign bank = addr[COL_W +: BANK_W];
    assign row  = addr[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int INTERVAL = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ack) t_d.pend = 1'b0;
        if (t_q.cnt == CW'(INTERVAL - 1)) begin
            t_d.cnt  = '0;
            t_d.pend = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pending = t_q.pend;
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
    parameter int CL = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issued,
    input  logic [DW-1:0] dq_in,
    output logic          valid,
    output logic [DW-1:0] data
);
    logic [CL-2:0] stage_q;
    logic          valid_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            stage_q[0] <= issued;
            for (int i = 1; i < CL - 1; i++) stage_q[i] <= stage_q[i-1];
            valid_q <= stage_q[CL-2];
            if (stage_q[CL-2]) data_q <= dq_in;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int INIT_WAIT    = 26600,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 9,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_close,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_be,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DW-1:0]     sd_dq_out,
    output logic              sd_dq_oe,
    output logic [DW/8-1:0]   sd_dqm,
    input  logic [DW-1:0]     sd_dq_in
);
    localparam int NB       = DW / 8;
    localparam int WAIT_MAX = INIT_WAIT + T_RFC + T_RP + T_RCD + T_MRD;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        seq_state_e                   st;
        logic [WAIT_W-1:0]            wait_cnt;
        logic [NBANK-1:0]             open;
        logic [NBANK-1:0][ROW_W-1:0]  row;
        logic                         cke;
        sd_cmd_e                      cmd;
        logic [BANK_W-1:0]            ba;
        logic [ROW_W-1:0]             a;
        logic [DW-1:0]                dq;
        logic                         dq_oe;
        logic [NB-1:0]                dqm;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic [ROW_W-1:0]  req_row;
    logic [BANK_W-1:0] req_bank;
    logic [COL_W-1:0]  req_col;
    logic              ref_pend;
    logic              ref_ack;
    logic              ready_c;
    logic              hit;

    sdram_addr_split u_split (
        .addr (req_addr),
        .row  (req_row),
        .bank (req_bank),
        .col  (req_col)
    );

    sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    sdram_rd_pipe #(.CL(CAS_LAT), .DW(DW)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .issued (r_q.cmd == CMD_RD),
        .dq_in  (sd_dq_in),
        .valid  (rd_valid),
        .data   (rd_data)
    );

    assign hit = r_q.open[req_bank] && (r_q.row[req_bank] == req_row);

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        r_d.ba    = '0;
        r_d.a     = '0;
        r_d.dq    = '0;
        r_d.dq_oe = 1'b0;
        r_d.dqm   = '0;
        ready_c   = 1'b0;
        ref_ack   = 1'b0;

        if (r_q.wait_cnt != '0) begin
            r_d.wait_cnt = r_q.wait_cnt - 1'b1;
        end else begin
            unique case (r_q.st)
                ST_POWER: begin
                    r_d.cke = 1'b1;
                    r_d.st  = ST_INIT_PRE;
                end
                ST_INIT_PRE: begin
                    r_d.cmd       = CMD_PRE;
                    r_d.a[AP_BIT] = 1'b1;
                    r_d.wait_cnt  = WAIT_W'(T_RP - 1);
                    r_d.st        = ST_INIT_REF1;
                end
                ST_INIT_REF1, ST_INIT_REF2: begin
                    r_d.cmd      = CMD_REF;
                    r_d.wait_cnt = WAIT_W'(T_RFC - 1);
                    r_d.st       = (r_q.st == ST_INIT_REF1) ? ST_INIT_REF2 : ST_INIT_MRS;
                end
                ST_INIT_MRS: begin
                    r_d.cmd      = CMD_MRS;
                    r_d.a        = MODE_WORD;
                    r_d.wait_cnt = WAIT_W'(T_MRD - 1);
                    r_d.st       = ST_IDLE;
                end
                default: begin
                    if (ref_pend) begin
                        if (|r_q.open) begin
                            r_d.cmd       = CMD_PRE;
                            r_d.a[AP_BIT] = 1'b1;
                            r_d.open      = '0;
                            r_d.wait_cnt  = WAIT_W'(T_RP - 1);
                        end else begin
                            r_d.cmd      = CMD_REF;
                            r_d.wait_cnt = WAIT_W'(T_RFC - 1);
                            ref_ack      = 1'b1;
                        end
                    end else if (req_valid) begin
                        r_d.ba = req_bank;
                        if (hit) begin
                            ready_c              = 1'b1;
                            r_d.cmd              = req_write ? CMD_WR : CMD_RD;
                            r_d.a[COL_W-1:0]     = req_col;
                            r_d.a[AP_BIT]        = req_close;
                            r_d.dq               = req_write ? req_wdata : '0;
                            r_d.dq_oe            = req_write;
                            r_d.dqm              = req_write ? ~req_be : '0;
                            if (req_close) begin
                                r_d.open[req_bank] = 1'b0;
                                r_d.wait_cnt       = WAIT_W'(T_RP - 1);
                            end
                        end else if (r_q.open[req_bank]) begin
                            r_d.cmd            = CMD_PRE;
                            r_d.open[req_bank] = 1'b0;
                            r_d.wait_cnt       = WAIT_W'(T_RP - 1);
                        end else begin
                            r_d.cmd            = CMD_ACT;
                            r_d.a              = req_row;
                            r_d.open[req_bank] = 1'b1;
                            r_d.row[req_bank]  = req_row;
                            r_d.wait_cnt       = WAIT_W'(T_RCD - 1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_POWER;
            r_q.cmd      <= CMD_NOP;
            r_q.wait_cnt <= WAIT_W'(INIT_WAIT - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = ready_c;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = r_q.cmd;
    assign sd_cke    = r_q.cke;
    assign sd_ba     = r_q.ba;
    assign sd_addr   = r_q.a;
    assign sd_dq_out = r_q.dq;
    assign sd_dq_oe  = r_q.dq_oe;
    assign sd_dqm    = r_q.dqm;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RFC = 9,
    parameter int T_MRD = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic [3:0] cmd,
    input logic       req_ready,
    input logic       rd_valid
);
    logic [15:0] gap_q;
    logic [3:0]  last_q;
    logic        busy;

    assign busy = (cmd != CMD_NOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            last_q <= CMD_NOP;
        end else if (busy) begin
            gap_q  <= 16'd1;
            last_q <= cmd;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS})
        else $error("illegal command code"); // R3
    AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == CMD_NOP)
        else $error("command while clock enable low"); // R2
    AST_READY_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (cmd == CMD_RD || cmd == CMD_WR))
        else $error("accept without column command"); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_RD |-> ##3 rd_valid)
        else $error("read data not on latency 3"); // R7
    AST_GAP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == CMD_ACT) |-> gap_q >= 16'(T_RCD))
        else $error("activate spacing short"); // R4
    AST_GAP_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == CMD_PRE) |-> gap_q >= 16'(T_RP))
        else $error("precharge spacing short"); // R4
    AST_GAP_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == CMD_REF) |-> gap_q >= 16'(T_RFC))
        else $error("refresh spacing short"); // R4
    AST_GAP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_q == CMD_MRS) |-> gap_q >= 16'(T_MRD))
        else $error("mode set spacing short"); // R4
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_RFC (T_RFC),
    .T_MRD (T_MRD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (sd_cke),
    .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
    import sdram_seq_pkg::*;

    localparam int DW = 16, NB = 2;
    localparam int IW = 12, TRCD = 2, TRP = 3, TRFC = 5, TMRD = 2, RI = 60;
    localparam int REF_BOUND = RI + TRCD + 2 * TRP + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_close = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [DW-1:0] rd_data, sd_dq_out;
    logic [DW-1:0] sd_dq_in = '0;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic [NB-1:0] sd_dqm;

    always #5 clk = ~clk;

    sdram_cmd_seq #(.DW(DW), .INIT_WAIT(IW), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC),
                    .T_MRD(TMRD), .REF_INTERVAL(RI)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_close(req_close), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // device model and monitor state
    logic [DW-1:0] dev [int];
    logic [DW-1:0] refm [int];
    logic [DW-1:0] expq [$];
    int rdq [$];
    logic [NBANK-1:0] mopen = '0;
    logic [ROW_W-1:0] mrow [NBANK];
    logic [DW-1:0] p1 = '0, p2 = '0;
    logic [3:0] cmd, last_cmd = CMD_NOP;
    int cyc = 0, last_cyc = 0, init_idx = 0, ckelow = 0, early_ready = 0, illegal = 0;
    int oe_bad = 0, refcount = 0, last_ref = 0, n_act = 0, n_pre1 = 0;
    bit mrs_seen = 0, ref_seen = 0, last_ap = 0;
    logic [BANK_W-1:0] last_pre1_ba = '0;
    int key, c0;
    logic [DW-1:0] cur;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] en);
        logic [DW-1:0] r = old;
        for (int i = 0; i < NB; i++) if (en[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            sd_dq_in = p2; p2 = p1; p1 = '0;
            if (!mrs_seen && !sd_cke) ckelow++;
            if (req_ready && !mrs_seen) early_ready++;
            if (!(cmd inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS})) illegal++;
            if (mrs_seen && !sd_cke) illegal++;
            if (sd_dq_oe != (cmd == CMD_WR)) oe_bad++;
            if (cmd != CMD_NOP) begin
                case (last_cmd)
                    CMD_ACT: chk(cyc - last_cyc >= TRCD, "R4 spacing after ACTIVE", cyc - last_cyc, TRCD);
                    CMD_PRE: chk(cyc - last_cyc >= TRP, "R4 spacing after PRECHARGE", cyc - last_cyc, TRP);
                    CMD_REF: chk(cyc - last_cyc >= TRFC, "R4 spacing after REFRESH", cyc - last_cyc, TRFC);
                    CMD_MRS: chk(cyc - last_cyc >= TMRD, "R4 spacing after MODE SET", cyc - last_cyc, TMRD);
                    default: ;
                endcase
                if (init_idx < 4) begin
                    case (init_idx)
                        0: chk(cmd == CMD_PRE && sd_addr[10], "R2 init step0 precharge-all", {cmd, sd_addr}, {CMD_PRE, 12'h400});
                        1: chk(cmd == CMD_REF, "R2 init step1 refresh", cmd, CMD_REF);
                        2: chk(cmd == CMD_REF, "R2 init step2 refresh", cmd, CMD_REF);
                        default: chk(cmd == CMD_MRS && sd_addr == 12'h030, "R2 init step3 mode word",
                                     {cmd, sd_addr}, {CMD_MRS, 12'h030});
                    endcase
                    init_idx++;
                    if (init_idx == 4) mrs_seen = 1;
                end else begin
                    case (cmd)
                        CMD_ACT: begin n_act++; mopen[sd_ba] = 1'b1; mrow[sd_ba] = sd_addr; end
                        CMD_PRE: begin
                            if (sd_addr[10]) mopen = '0;
                            else begin n_pre1++; last_pre1_ba = sd_ba; mopen[sd_ba] = 1'b0; end
                        end
                        CMD_REF: begin
                            chk(mopen == '0, "R11 banks closed at refresh", mopen, 0);
                            if (ref_seen) chk(cyc - last_ref <= REF_BOUND, "R11 refresh spacing", cyc - last_ref, REF_BOUND);
                            ref_seen = 1; last_ref = cyc; refcount++;
                        end
                        CMD_WR, CMD_RD: begin
                            chk(mopen[sd_ba], "R5 column to open bank", mopen[sd_ba], 1);
                            key = int'({mrow[sd_ba], sd_ba, sd_addr[COL_W-1:0]});
                            cur = dev.exists(key) ? dev[key] : '0;
                            if (cmd == CMD_WR) dev[key] = merge(cur, sd_dq_out, ~sd_dqm);
                            else begin p1 = cur; rdq.push_back(cyc); end
                            last_ap = sd_addr[10];
                            if (sd_addr[10]) mopen[sd_ba] = 1'b0;
                        end
                        default: ;
                    endcase
                end
                last_cmd = cmd; last_cyc = cyc;
            end
            if (rd_valid) begin
                if (rdq.size() == 0 || expq.size() == 0) chk(0, "R7 unexpected rd_valid", 1, 0);
                else begin
                    c0 = rdq.pop_front();
                    chk(cyc - c0 == 3, "R7 read latency", cyc - c0, 3);
                    cur = expq.pop_front();
                    chk(rd_data == cur, "R5/R8 read data", rd_data, cur);
                end
            end
        end
    end

    task automatic op(input bit we, input int addr, input logic [DW-1:0] d,
                      input logic [NB-1:0] be, input bit close);
        req_write = we; req_addr = ADDR_W'(addr); req_wdata = d; req_be = be;
        req_close = close; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (we) refm[addr] = merge(refm.exists(addr) ? refm[addr] : '0, d, be);
        else expq.push_back(refm.exists(addr) ? refm[addr] : '0);
    endtask

    task automatic wait_ref();
        int r0 = refcount;
        while (refcount == r0) @(negedge clk);
        #1;
    endtask

    function automatic int fa(int row, int bank, int col);
        return (row << 11) | (bank << 9) | col;
    endfunction

    initial begin
        int a0, p0, cols [4];
        cols = '{0, 1, 256, 511};
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(sd_cke == 1'b0, "R1 reset cke", sd_cke, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1 reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
        chk(req_ready == 1'b0, "R1 reset ready", req_ready, 0);
        chk(rd_valid == 1'b0, "R1 reset rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        #1;
        op(1, fa(9, 3, 7), 16'hA5C3, 2'b11, 0);   // R2: waits through power-up
        chk(ckelow >= IW, "R2 cke low time", ckelow, IW);
        chk(early_ready == 0, "R2 no accept before mode set", early_ready, 0);

        wait_ref();                               // R9 row hit
        a0 = n_act; p0 = n_pre1;
        op(1, fa(5, 1, 3), 16'h1234, 2'b11, 0);
        op(0, fa(5, 1, 3), '0, 2'b00, 0);
        chk(n_act - a0 == 1 && n_pre1 == p0, "R9 row hit adds no activate", n_act - a0, 1);
        a0 = n_act;                               // R9 row miss
        op(0, fa(6, 1, 3), '0, 2'b00, 0);
        chk(n_pre1 - p0 == 1, "R9 miss single-bank precharge", n_pre1 - p0, 1);
        chk(last_pre1_ba == 2'd1, "R9 miss precharge bank", last_pre1_ba, 1);
        chk(n_act - a0 == 1, "R9 miss reactivates", n_act - a0, 1);

        wait_ref();                               // R10 auto close
        p0 = n_pre1;
        op(1, fa(7, 2, 0), 16'hBEEF, 2'b11, 1);
        @(negedge clk); #1;
        chk(last_ap == 1'b1, "R10 column carries auto-close", last_ap, 1);
        a0 = n_act;
        op(0, fa(7, 2, 0), '0, 2'b00, 0);
        chk(n_act - a0 == 1 && n_pre1 == p0, "R10 reopen without precharge", n_act - a0, 1);

        // sweep: full writes, masked writes, reads, across banks/rows/columns
        for (int pass = 0; pass < 3; pass++)
            for (int r = 0; r < 4; r++)
                for (int b = 0; b < 4; b++)
                    for (int ci = 0; ci < 4; ci++) begin
                        int ad = fa(r * 37, b, cols[ci]);
                        logic [DW-1:0] dv = DW'((ad * 13 + pass * 4099) ^ 16'h5A00);
                        bit cl = ((r + b + ci + pass) % 3) == 0;
                        if (pass == 0) op(1, ad, dv, 2'b11, cl);
                        else if (pass == 1) op(1, ad, dv, NB'(ci), cl);   // R8 byte enables 00..11
                        else op(0, ad, '0, 2'b00, cl);
                    end

        repeat (20) @(negedge clk);
        #1;
        chk(expq.size() == 0 && rdq.size() == 0, "R7 all reads returned", expq.size(), 0);
        chk(illegal == 0, "R3 command codes and cke", illegal, 0);
        chk(early_ready == 0, "R6 no early accept", early_ready, 0);
        chk(oe_bad == 0, "R8 output enable only on write", oe_bad, 0);
        chk(init_idx == 4, "R2 init sequence complete", init_idx, 4);
        chk(refcount > 0 && cyc - last_ref <= REF_BOUND, "R11 refresh still running", cyc - last_ref, REF_BOUND);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule